// File: doc/BRIEF.md
# Symmetric Decimate-by-4 FIR

This block is the second rate-reduction stage of a multi-channel audio capture path. It accepts a single stream of 32-bit signed PCM samples, each tagged with one of four channel numbers, and returns one filtered 32-bit sample per channel for every four samples that channel receives. The four channels share one arithmetic engine and one delay-line store. Each channel keeps its own write pointer and its own decimation phase.

The filter is a 16-tap linear-phase low-pass. Because the impulse response is mirror-symmetric, only eight distinct coefficients exist. Each coefficient that is fetched multiplies two samples, one near the head of the window and its mirror image near the tail. Every product is a full 32 x 32 multiply, and the products are summed into a 64-bit signed accumulator with no rounding along the way. Each channel's history is stored twice over, in a 32-entry line. A 16-sample window therefore always lies in consecutive addresses and needs no wrap logic on the read side.

When a channel reaches its fourth input, the engine walks the window in four groups of four taps, one group per clock. It then shifts the sum right, saturates it and presents it on the output stream for a single cycle.

Top module: `pcm_decim4_fir`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0. After reset every channel's history reads as zero, and its input count starts at zero.
- R2: A channel produces exactly one output per four accepted inputs, on its 4th, 8th, 12th, ... input. No other input causes an output.
- R3: With x[0] the newest sample of the channel and x[k] the sample k inputs earlier, the accumulated value is S = sum over k=0..15 of h[k]*x[k]. The coefficients are symmetric, h[k] = h[15-k]. For k=0..7, h[k] = {-2, -4, 3, 18, 45, 82, 118, 140}[k] * 2^21, listed in order from the outer taps inward. Every product is exact, and S is exact in 64-bit signed arithmetic.
- R4: The output value is S shifted arithmetically right by 30 bits, so it rounds toward minus infinity, including for negative sums.
- R5: When the shifted value is above 2^31-1, the output is 0x7FFFFFFF. When it is below -2^31, the output is 0x80000000.
- R6: `out_valid` is high for exactly one cycle. That cycle is the 5th clock after the cycle in which the triggering input was presented with `in_valid` high. `out_ch` then carries that input's channel number.
- R7: A channel's outputs depend only on the samples presented with that channel number, whatever the interleaving with the other channels.
- R8: `in_valid` pulses must be at least 5 cycles apart. At that spacing, a new input may arrive on any channel while an output is being computed, including the channel being computed, without changing that output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present this cycle |
| in_ch | input | 2 | Channel number of the input sample |
| in_data | input | 32 | Input sample, two's complement |
| out_valid | output | 1 | Output sample present this cycle |
| out_ch | output | 2 | Channel number of the output sample |
| out_data | output | 32 | Filtered, decimated output sample, two's complement |

## Verification
The bound checker watches the timing on every cycle. It confirms that each output pulse lasts one cycle and follows its triggering input by exactly five cycles, on the same channel. It also confirms that outputs fall only on a channel's input-count boundary, that inputs keep the minimum spacing, and that a new computation never starts while one is still running. Only the bench's scenarios can show whether the numbers are right. That covers the mirrored coefficient pairing, the floor behaviour of the shift on negative sums, saturation at both rails, and isolation between interleaved channels. It also covers history surviving the wrap of each write pointer, and a same-channel write landing in the middle of a computation.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    localparam int SAMP_W    = 32;
    localparam int ACC_W     = 64;
    localparam int N_CH      = 4;
    localparam int N_TAP     = 16;
    localparam int DECIM     = 4;
    localparam int OUT_SHIFT = 30;

    localparam int N_UNIQ   = N_TAP / 2;
    localparam int N_GRP    = N_TAP / 4;
    localparam int LINE_LEN = 2 * N_TAP;
    localparam int CH_W     = $clog2(N_CH);
    localparam int IDX_W    = $clog2(N_TAP);
    localparam int LINE_W   = $clog2(LINE_LEN);
    localparam int GRP_W    = $clog2(N_GRP);
    localparam int PH_W     = $clog2(DECIM);
    localparam int UQ_W     = $clog2(N_UNIQ);
    localparam int GAP_MIN  = N_GRP + 1;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    localparam acc_t SAT_HI = acc_t'(64'sh0000_0000_7FFF_FFFF);
    localparam acc_t SAT_LO = acc_t'(-64'sh0000_0000_8000_0000);

    // one queued filter evaluation: which channel, where its window starts
    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [IDX_W-1:0] base;
    } job_t;

    // four window samples for one tap group g:
    // hd0 = x[2g], hd1 = x[2g+1], tl0 = x[N_TAP-2-2g], tl1 = x[N_TAP-1-2g]
    typedef struct packed {
        samp_t hd0;
        samp_t hd1;
        samp_t tl0;
        samp_t tl1;
    } quad_t;

    // half of the symmetric response, outer taps first
    function automatic samp_t half_coef(input logic [UQ_W-1:0] k);
        case (k)
            3'd0:    return samp_t'(-32'sd4194304);
            3'd1:    return samp_t'(-32'sd8388608);
            3'd2:    return samp_t'(32'sd6291456);
            3'd3:    return samp_t'(32'sd37748736);
            3'd4:    return samp_t'(32'sd94371840);
            3'd5:    return samp_t'(32'sd171966464);
            3'd6:    return samp_t'(32'sd247463936);
            default: return samp_t'(32'sd293601280);
        endcase
    endfunction

    // rescale the accumulator and clamp it to the sample range
    function automatic samp_t clip(input acc_t a);
        acc_t s;
        s = a >>> OUT_SHIFT;
        if (s > SAT_HI)
            return samp_t'(32'h7FFF_FFFF);
        else if (s < SAT_LO)
            return samp_t'(32'h8000_0000);
        else
            return s[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/pdf_dline.sv
module pdf_dline
    import pdf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  samp_t            wr_data,
    output logic             trig,
    output job_t             trig_job,
    input  job_t             rd_job,
    input  logic [GRP_W-1:0] rd_grp,
    output quad_t            rd_q
);

    samp_t            line_q [N_CH][LINE_LEN];
    logic [IDX_W-1:0] wr_idx [N_CH];
    logic [PH_W-1:0]  phase  [N_CH];

    // the write that completes a group of DECIM inputs launches a job
    assign trig     = wr_en && (phase[wr_ch] == PH_W'(DECIM - 1));
    assign trig_job = '{ch: wr_ch, base: wr_idx[wr_ch]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N_CH; c++) begin
                for (int e = 0; e < LINE_LEN; e++) begin
                    line_q[c][e] <= '0;
                end
                wr_idx[c] <= '0;
                phase[c]  <= '0;
            end
        end else if (wr_en) begin
            // same sample in both halves, so any window is contiguous
            line_q[wr_ch][{1'b0, wr_idx[wr_ch]}] <= wr_data;
            line_q[wr_ch][{1'b1, wr_idx[wr_ch]}] <= wr_data;
            wr_idx[wr_ch] <= wr_idx[wr_ch] - 1'b1;
            phase[wr_ch]  <= phase[wr_ch] + 1'b1;
        end
    end

    logic [LINE_W-1:0] base_ext;
    logic [LINE_W-1:0] head_off;

    always_comb begin
        base_ext = LINE_W'(rd_job.base);
        head_off = LINE_W'({rd_grp, 1'b0});
        rd_q.hd0 = line_q[rd_job.ch][base_ext + head_off];
        rd_q.hd1 = line_q[rd_job.ch][base_ext + head_off + LINE_W'(1)];
        rd_q.tl0 = line_q[rd_job.ch][base_ext + LINE_W'(N_TAP - 2) - head_off];
        rd_q.tl1 = line_q[rd_job.ch][base_ext + LINE_W'(N_TAP - 1) - head_off];
    end

endmodule

// File: rtl/pdf_mac.sv
module pdf_mac
    import pdf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  job_t             start_job,
    output job_t             rd_job,
    output logic [GRP_W-1:0] rd_grp,
    input  quad_t            rd_q,
    output logic             busy,
    output logic             out_valid,
    output logic [CH_W-1:0]  out_ch,
    output samp_t            out_data
);

    job_t             job_q;
    logic [GRP_W-1:0] grp_q;
    logic             busy_q;
    acc_t             acc_q;

    samp_t c_lo;
    samp_t c_hi;
    acc_t  grp_sum;
    acc_t  acc_nxt;

    always_comb begin
        // two fetches per group, each serving a head tap and its mirror
        c_lo    = half_coef({grp_q, 1'b0});
        c_hi    = half_coef({grp_q, 1'b1});
        grp_sum = acc_t'(rd_q.hd0) * acc_t'(c_lo)
                + acc_t'(rd_q.hd1) * acc_t'(c_hi)
                + acc_t'(rd_q.tl0) * acc_t'(c_hi)
                + acc_t'(rd_q.tl1) * acc_t'(c_lo);
        acc_nxt = acc_q + grp_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q     <= '0;
            grp_q     <= '0;
            busy_q    <= 1'b0;
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                job_q  <= start_job;
                grp_q  <= '0;
                acc_q  <= '0;
            end else if (busy_q) begin
                acc_q <= acc_nxt;
                grp_q <= grp_q + 1'b1;
                if (grp_q == GRP_W'(N_GRP - 1)) begin
                    busy_q    <= 1'b0;
                    out_valid <= 1'b1;
                    out_ch    <= job_q.ch;
                    out_data  <= clip(acc_nxt);
                end
            end
        end
    end

    assign rd_job = job_q;
    assign rd_grp = grp_q;
    assign busy   = busy_q;

endmodule

// File: rtl/pcm_decim4_fir.sv
module pcm_decim4_fir
    import pdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  in_ch,
    input  logic [31:0] in_data,
    output logic        out_valid,
    output logic [1:0]  out_ch,
    output logic [31:0] out_data
);

    logic             dl_trig;
    job_t             dl_job;
    job_t             mac_job;
    logic [GRP_W-1:0] mac_grp;
    quad_t            dl_quad;
    logic             mac_busy;
    samp_t            mac_data;

    pdf_dline u_dline (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (in_valid),
        .wr_ch    (in_ch),
        .wr_data  (samp_t'(in_data)),
        .trig     (dl_trig),
        .trig_job (dl_job),
        .rd_job   (mac_job),
        .rd_grp   (mac_grp),
        .rd_q     (dl_quad)
    );

    pdf_mac u_mac (
        .clk       (clk),
        .rst       (rst),
        .start     (dl_trig),
        .start_job (dl_job),
        .rd_job    (mac_job),
        .rd_grp    (mac_grp),
        .rd_q      (dl_quad),
        .busy      (mac_busy),
        .out_valid (out_valid),
        .out_ch    (out_ch),
        .out_data  (mac_data)
    );

    assign out_data = mac_data;

endmodule

// File: rtl/pdf_chk.sv
module pdf_chk
    import pdf_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [CH_W-1:0] in_ch,
    input logic            out_valid,
    input logic [CH_W-1:0] out_ch,
    input logic            busy,
    input logic            trig
);

    logic [2:0]      since;
    logic [PH_W-1:0] seen [N_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= 3'd7;
            for (int c = 0; c < N_CH; c++) seen[c] <= '0;
        end else begin
            if (in_valid) begin
                since        <= '0;
                seen[in_ch]  <= seen[in_ch] + 1'b1;
            end else if (since != 3'd7) begin
                since <= since + 1'b1;
            end
        end
    end

    // R1: no output in the cycle after reset
    p_reset_r1: assert property (@(posedge clk) rst |=> !out_valid);

    // R6: output follows its trigger by five cycles, same channel
    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid, 5) && ($past(in_ch, 5) == out_ch)));

    // R6: single-cycle pulse
    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R2: outputs land on a channel's input-count boundary
    p_decim_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen[out_ch] == '0));

    // R8: minimum spacing between accepted inputs
    p_spacing_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (since >= 3'(GAP_MIN - 1)));

    // R8: a job never starts over a running one
    p_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        trig |-> !busy);

endmodule

bind pcm_decim4_fir pdf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ch     (in_ch),
    .out_valid (out_valid),
    .out_ch    (out_ch),
    .busy      (mac_busy),
    .trig      (dl_trig)
);

// File: tb/sim_pcm_decim4_fir.sv
module sim_pcm_decim4_fir;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_ch = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [1:0]  out_ch;
    logic [31:0] out_data;

    always #2 clk = ~clk;

    pcm_decim4_fir u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ch     (in_ch),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ch    (out_ch),
        .out_data  (out_data)
    );

    typedef struct {
        int          ch;
        logic [31:0] data;
        longint      t;
        string       tag;
    } exp_t;

    exp_t   expq[$];
    longint hist [4][16];
    int     icnt [4];
    longint cyc = 0;
    int     total = 0;
    int     bad = 0;
    int     n_exp = 0;
    int     n_seen = 0;
    bit     running = 1'b0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // coefficient h[k] from R3
    function automatic longint hcoef(input int k);
        int     u;
        longint m;
        u = (k < 8) ? k : 15 - k;
        case (u)
            0: m = -2;
            1: m = -4;
            2: m = 3;
            3: m = 18;
            4: m = 45;
            5: m = 82;
            6: m = 118;
            default: m = 140;
        endcase
        return m * 64'sd2097152;
    endfunction

    // R4 floor shift, R5 clamp
    function automatic logic [31:0] ref_out(input longint s);
        longint q;
        q = s >>> 30;
        if (q > 64'sd2147483647) return 32'h7FFF_FFFF;
        if (q < -64'sd2147483648) return 32'h8000_0000;
        return q[31:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic send(input int ch, input logic [31:0] d, input int gap, input string tag);
        longint s;
        exp_t   e;
        @(negedge clk);
        in_valid = 1'b1;
        in_ch    = ch[1:0];
        in_data  = d;
        for (int k = 15; k > 0; k--) hist[ch][k] = hist[ch][k-1];
        hist[ch][0] = longint'($signed(d));
        icnt[ch]++;
        if (icnt[ch] % 4 == 0) begin
            s = 0;
            for (int k = 0; k < 16; k++) s += hcoef(k) * hist[ch][k];
            e.ch   = ch;
            e.data = ref_out(s);
            e.t    = cyc;
            e.tag  = tag;
            expq.push_back(e);
            n_exp++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap - 2) @(negedge clk);
    endtask

    // output monitor: R6 timing and channel, data under the scenario tag
    always @(negedge clk) begin
        if (running && !rst) begin
            if (expq.size() > 0 && cyc == expq[0].t + 5) begin
                exp_t e;
                e = expq.pop_front();
                n_seen++;
                chk(out_valid == 1'b1 && out_ch == e.ch[1:0], "R6", "valid/channel",
                    longint'({out_valid, out_ch}), longint'({1'b1, e.ch[1:0]}));
                chk(out_data == e.data, e.tag, "data", longint'(out_data), longint'(e.data));
            end else if (out_valid) begin
                chk(1'b0, "R2", "unexpected output channel", longint'(out_ch), 0);
            end
        end
    end

    initial begin
        int unsigned r;
        for (int c = 0; c < 4; c++) begin
            icnt[c] = 0;
            for (int k = 0; k < 16; k++) hist[c][k] = 0;
        end
        r = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        rst = 1'b0;
        running = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);

        // R1: first output sees zero history
        for (int i = 0; i < 4; i++) send(1, 32'h1000_0000, 6, "R1");

        // R3: impulse walks through the taps, pointer wraps
        send(0, 32'h4000_0000, 6, "R3");
        for (int i = 0; i < 23; i++) send(0, 32'h0, 5, "R3");

        // R5: both rails
        for (int i = 0; i < 24; i++) send(2, 32'h7FFF_FFFF, 5, "R5");
        for (int i = 0; i < 24; i++) send(3, 32'h8000_0000, 5, "R5");

        // R4: small negative sums must floor
        for (int i = 0; i < 16; i++) send(0, -(32'($urandom % 7) + 32'd1), 5, "R4");

        // R7: round-robin interleave
        for (int i = 0; i < 40; i++) send(i % 4, 32'(i * 123456789), 6, "R7");

        // R8: minimum spacing on one channel, mid-computation writes
        for (int i = 0; i < 24; i++) send(1, $urandom, 5, "R8");

        // R3: constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] d;
            d = $urandom;
            if ($urandom % 2 == 1) d = 32'($signed(d) >>> ($urandom % 24));
            send(int'($urandom % 4), d, 5 + int'($urandom % 4), "R3");
        end

        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R2", "outputs outstanding", longint'(expq.size()), 0);
        chk(n_seen == n_exp, "R2", "output count", longint'(n_seen), longint'(n_exp));
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule